// File: doc/BRIEF.md
# Indirect memory access register unit

This unit gives a host access to an internal single-port memory of 16-bit words through two registers. One is a command register that holds an instruction code, a target word address and a completion flag. The other is a 16-bit data register. The host loads the data register and then writes the command register. That command write starts exactly one memory operation.

A write operation stores the data register at the chosen address. It then reads the same word back and leaves it in the data register, so the host sees what the memory actually holds. A read operation loads the data register from the chosen address. The completion flag drops on the edge that accepts the command and rises again when the whole sequence has finished. The host polls it through ordinary register reads.

Reads of either register are combinational and have no side effects. While an operation is running, host writes to both registers are dropped, so the operation in flight cannot be disturbed.

Top module: `ind_mem_port`

## Requirements
- R1: After reset the command register reads 16'h0001 (flag = 1, instruction = 0, address = 0) and the data register reads 16'h0000.
- R2: Command register layout: instruction in bits 15:12, address in bits 8:1, flag in bit 0, and bits 11:9 always read 0. A host write loads the instruction and address but never the flag. Host reads never change any state.
- R3: Instruction 4'b0011 stores the data register at the address and then loads the data register with the word read back from that address. The flag reads 0 for exactly 3 cycles after the accepting edge.
- R4: Instruction 4'b0101 loads the data register with the word at the address. The flag reads 0 for exactly 2 cycles after the accepting edge.
- R5: Any other instruction code makes no memory access and leaves the data register unchanged. The flag reads 0 for exactly 1 cycle.
- R6: The flag is 0 in the cycle right after the edge that accepts a command write, and it is 1 only when the operation has completed.
- R7: A data register write takes effect only when host_be is 2'b11. A write with any other byte-enable value leaves the data register unchanged.
- R8: While the flag is 0, host writes to the data register and to the command register are ignored.
- R9: Memory words keep their values across operations, and both address 0 and address 2^ADDR_W-1 can be written and read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe, sampled on the clock edge |
| host_sel | input | 1 | Register select: 0 = command register, 1 = data register |
| host_be | input | 2 | Byte enables for the host write |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Combinational read of the selected register |

## Verification
The host port is registered, so a register write shows on host_rdata in the cycle that follows its edge. The flag falls in that same cycle. After the accepting edge, a write command completes 3 edges later, a read command 2 edges later and a reserved code 1 edge later, and the data register changes together with the flag. The bench keeps a behavioural model that counts down these same numbers of edges. It compares the selected register against the model half a cycle after every edge, and it also measures how long the flag stays low against the number each requirement states.

// File: rtl/imp_pkg.sv
package imp_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_STORE,
        ST_FETCH,
        ST_LATCH,
        ST_SKIP
    } imp_state_e;

    typedef enum logic [1:0] {
        OPK_STORE,
        OPK_FETCH,
        OPK_NONE
    } imp_kind_e;

    localparam logic [3:0] CODE_STORE = 4'b0011;
    localparam logic [3:0] CODE_FETCH = 4'b0101;

endpackage

// File: rtl/imp_instr_dec.sv
module imp_instr_dec
    import imp_pkg::*;
#(
    parameter int INSTR_W = 4
) (
    input  logic [INSTR_W-1:0] code_i,
    output imp_kind_e          kind_o
);

    localparam logic [INSTR_W-1:0] STORE_C = INSTR_W'(CODE_STORE);
    localparam logic [INSTR_W-1:0] FETCH_C = INSTR_W'(CODE_FETCH);

    always_comb begin
        if (code_i == STORE_C) begin
            kind_o = OPK_STORE;
        end else if (code_i == FETCH_C) begin
            kind_o = OPK_FETCH;
        end else begin
            kind_o = OPK_NONE;
        end
    end

endmodule

// File: rtl/imp_host_if.sv
module imp_host_if #(
    parameter int DATA_W  = 16,
    parameter int ADDR_W  = 8,
    parameter int INSTR_W = 4,
    parameter int BE_W    = DATA_W / 8
) (
    input  logic               host_wr_i,
    input  logic               host_sel_i,
    input  logic [BE_W-1:0]    host_be_i,
    input  logic [DATA_W-1:0]  host_wdata_i,
    input  logic [INSTR_W-1:0] instr_q_i,
    input  logic [ADDR_W-1:0]  addr_q_i,
    input  logic               done_q_i,
    input  logic [DATA_W-1:0]  data_q_i,
    output logic               cmd_wr_o,
    output logic               data_wr_o,
    output logic [INSTR_W-1:0] wr_instr_o,
    output logic [ADDR_W-1:0]  wr_addr_o,
    output logic [DATA_W-1:0]  host_rdata_o
);

    localparam int PAD_W = DATA_W - INSTR_W - ADDR_W - 1;

    logic [DATA_W-1:0] cmd_word;

    // Field positions: flag at bit 0, address just above it, code at the top.
    generate
        if (PAD_W > 0) begin : g_pad
            assign cmd_word = {instr_q_i, {PAD_W{1'b0}}, addr_q_i, done_q_i};
        end else begin : g_nopad
            assign cmd_word = {instr_q_i, addr_q_i, done_q_i};
        end
    endgenerate

    always_comb begin
        cmd_wr_o     = host_wr_i && !host_sel_i;
        data_wr_o    = host_wr_i && host_sel_i && (&host_be_i);
        wr_instr_o   = host_wdata_i[DATA_W-1 -: INSTR_W];
        wr_addr_o    = host_wdata_i[ADDR_W:1];
        host_rdata_o = host_sel_i ? data_q_i : cmd_word;
    end

endmodule

// File: rtl/imp_ram.sv
module imp_ram #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              we_i,
    input  logic              re_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [DATA_W-1:0] rd_q;

    always_ff @(posedge clk) begin
        if (we_i) begin
            mem_q[addr_i] <= wdata_i;
        end
        if (re_i) begin
            rd_q <= mem_q[addr_i];
        end
    end

    assign rdata_o = rd_q;

    AST_ONE_PORT_OP: assert property (@(posedge clk) $onehot0({we_i, re_i})); // R9

endmodule

// File: rtl/imp_seq.sv
module imp_seq
    import imp_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int ADDR_W  = 8,
    parameter int INSTR_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_wr_i,
    input  logic               data_wr_i,
    input  imp_kind_e          kind_i,
    input  logic [INSTR_W-1:0] wr_instr_i,
    input  logic [ADDR_W-1:0]  wr_addr_i,
    input  logic [DATA_W-1:0]  wr_data_i,
    input  logic [DATA_W-1:0]  ram_rdata_i,
    output logic               ram_we_o,
    output logic               ram_re_o,
    output logic [ADDR_W-1:0]  ram_addr_o,
    output logic [DATA_W-1:0]  ram_wdata_o,
    output logic [INSTR_W-1:0] instr_q_o,
    output logic [ADDR_W-1:0]  addr_q_o,
    output logic               done_q_o,
    output logic [DATA_W-1:0]  data_q_o
);

    typedef struct packed {
        imp_state_e         st;
        logic [INSTR_W-1:0] instr;
        logic [ADDR_W-1:0]  addr;
        logic               done;
        logic [DATA_W-1:0]  data;
    } seq_t;

    seq_t s_d, s_q;
    logic ram_we_d, ram_re_d;

    always_comb begin
        s_d      = s_q;
        ram_we_d = 1'b0;
        ram_re_d = 1'b0;
        unique case (s_q.st)
            ST_IDLE: begin
                if (cmd_wr_i) begin
                    s_d.instr = wr_instr_i;
                    s_d.addr  = wr_addr_i;
                    s_d.done  = 1'b0;
                    unique case (kind_i)
                        OPK_STORE: s_d.st = ST_STORE;
                        OPK_FETCH: s_d.st = ST_FETCH;
                        default:   s_d.st = ST_SKIP;
                    endcase
                end else if (data_wr_i) begin
                    s_d.data = wr_data_i;
                end
            end
            ST_STORE: begin
                ram_we_d = 1'b1;
                s_d.st   = ST_FETCH;
            end
            ST_FETCH: begin
                ram_re_d = 1'b1;
                s_d.st   = ST_LATCH;
            end
            ST_LATCH: begin
                s_d.data = ram_rdata_i;
                s_d.done = 1'b1;
                s_d.st   = ST_IDLE;
            end
            ST_SKIP: begin
                s_d.done = 1'b1;
                s_d.st   = ST_IDLE;
            end
            default: begin
                s_d.done = 1'b1;
                s_d.st   = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{st: ST_IDLE, instr: '0, addr: '0, done: 1'b1, data: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign ram_we_o    = ram_we_d;
    assign ram_re_o    = ram_re_d;
    assign ram_addr_o  = s_q.addr;
    assign ram_wdata_o = s_q.data;
    assign instr_q_o   = s_q.instr;
    assign addr_q_o    = s_q.addr;
    assign done_q_o    = s_q.done;
    assign data_q_o    = s_q.data;

    AST_CMD_CLEARS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr_i && done_q_o) |=> !done_q_o); // R6
    AST_STORE_THEN_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we_o |=> (ram_re_o && $stable(ram_addr_o))); // R3
    AST_FETCH_COMPLETES: assert property (@(posedge clk) disable iff (!rst_n)
        ram_re_o |=> !done_q_o ##1 done_q_o); // R4
    AST_SKIP_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr_i && done_q_o && kind_i == OPK_NONE) |=>
        (!ram_we_o && !ram_re_o && !done_q_o) ##1 (done_q_o && !ram_we_o && !ram_re_o)); // R5
    AST_BUSY_HOLDS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        !done_q_o |=> ($stable(instr_q_o) && $stable(addr_q_o))); // R8
    AST_BUSY_HOLDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        !done_q_o |=> ($stable(data_q_o) || done_q_o)); // R8

endmodule

// File: rtl/ind_mem_port.sv
module ind_mem_port
    import imp_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int ADDR_W  = 8,
    parameter int INSTR_W = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  host_wr,
    input  logic                  host_sel,
    input  logic [DATA_W/8-1:0]   host_be,
    input  logic [DATA_W-1:0]     host_wdata,
    output logic [DATA_W-1:0]     host_rdata
);

    localparam int BE_W = DATA_W / 8;

    logic               cmd_wr, data_wr;
    logic [INSTR_W-1:0] wr_instr, instr_q;
    logic [ADDR_W-1:0]  wr_addr, addr_q, ram_addr;
    logic               done_q, ram_we, ram_re;
    logic [DATA_W-1:0]  data_q, ram_wdata, ram_rdata;
    imp_kind_e          kind;

    imp_host_if #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .INSTR_W(INSTR_W), .BE_W(BE_W)) u_host (
        .host_wr_i   (host_wr),
        .host_sel_i  (host_sel),
        .host_be_i   (host_be),
        .host_wdata_i(host_wdata),
        .instr_q_i   (instr_q),
        .addr_q_i    (addr_q),
        .done_q_i    (done_q),
        .data_q_i    (data_q),
        .cmd_wr_o    (cmd_wr),
        .data_wr_o   (data_wr),
        .wr_instr_o  (wr_instr),
        .wr_addr_o   (wr_addr),
        .host_rdata_o(host_rdata)
    );

    imp_instr_dec #(.INSTR_W(INSTR_W)) u_dec (
        .code_i(wr_instr),
        .kind_o(kind)
    );

    imp_seq #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .INSTR_W(INSTR_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_wr_i   (cmd_wr),
        .data_wr_i  (data_wr),
        .kind_i     (kind),
        .wr_instr_i (wr_instr),
        .wr_addr_i  (wr_addr),
        .wr_data_i  (host_wdata),
        .ram_rdata_i(ram_rdata),
        .ram_we_o   (ram_we),
        .ram_re_o   (ram_re),
        .ram_addr_o (ram_addr),
        .ram_wdata_o(ram_wdata),
        .instr_q_o  (instr_q),
        .addr_q_o   (addr_q),
        .done_q_o   (done_q),
        .data_q_o   (data_q)
    );

    imp_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ram (
        .clk    (clk),
        .we_i   (ram_we),
        .re_i   (ram_re),
        .addr_i (ram_addr),
        .wdata_i(ram_wdata),
        .rdata_o(ram_rdata)
    );

    AST_PARTIAL_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_sel && !(&host_be)) |=> $stable(data_q)); // R7
    AST_FLAG_NOT_WRITABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && !host_sel && done_q) |=> !done_q); // R2

endmodule

// File: tb/ind_mem_port_tb_top.sv
`timescale 1ns/100ps
module ind_mem_port_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0;
    logic        host_sel = 1'b0;
    logic [1:0]  host_be = 2'b00;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;

    int    total = 0;
    int    fails = 0;
    bit    live = 1'b0;
    bit    ended = 1'b0;
    string cur_req = "R1";

    // behavioural reference model
    logic [3:0]  m_instr;
    logic [7:0]  m_addr;
    logic        m_done;
    logic [15:0] m_data;
    int          rem;
    int          m_op;
    logic [15:0] mmem [int];

    always #2.5 clk = ~clk;

    ind_mem_port dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .host_wr   (host_wr),
        .host_sel  (host_sel),
        .host_be   (host_be),
        .host_wdata(host_wdata),
        .host_rdata(host_rdata)
    );

    function automatic logic [15:0] cmd_exp();
        return {m_instr, 3'b000, m_addr, m_done};
    endfunction

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic report();
        if (!ended) begin
            ended = 1'b1;
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_instr = '0; m_addr = '0; m_done = 1'b1; m_data = '0; rem = 0; m_op = 0;
        end else if (rem > 0) begin
            rem--;
            if (m_op == 1 && rem == 2) mmem[int'(m_addr)] = m_data;
            if (rem == 0) begin
                if (m_op != 3) m_data = mmem[int'(m_addr)];
                m_done = 1'b1;
            end
        end else if (host_wr) begin
            if (!host_sel) begin
                m_instr = host_wdata[15:12];
                m_addr  = host_wdata[8:1];
                m_done  = 1'b0;
                if (host_wdata[15:12] == 4'b0011) begin m_op = 1; rem = 3; end
                else if (host_wdata[15:12] == 4'b0101) begin m_op = 2; rem = 2; end
                else begin m_op = 3; rem = 1; end
            end else if (host_be == 2'b11) begin
                m_data = host_wdata;
            end
        end
    end

    always @(negedge clk) begin
        if (live) chk(cur_req, host_rdata, host_sel ? m_data : cmd_exp());
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++; fails++;
        $display("FAIL watchdog: actual hung expected done");
        report();
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            host_sel = ~host_sel;
            @(posedge clk); #1;
        end
    endtask

    task automatic hwrite(input logic sel, input logic [1:0] be, input logic [15:0] d);
        host_wr = 1'b1; host_sel = sel; host_be = be; host_wdata = d;
        @(posedge clk); #1;
        host_wr = 1'b0; host_be = 2'b00;
    endtask

    function automatic logic [15:0] cmdw(input logic [3:0] code, input logic [7:0] a);
        return {code, 3'b000, a, 1'b0};
    endfunction

    // returns cycles the flag stays low after the accepting edge
    task automatic wait_flag(output int n);
        host_sel = 1'b0; #1;
        chk("R6 flag cleared by command", {15'd0, host_rdata[0]}, 16'd0);
        n = 0;
        while (host_rdata[0] == 1'b0 && n < 10) begin
            @(posedge clk); #1;
            n++;
        end
    endtask

    task automatic rd_data(input string req, input logic [15:0] exp);
        host_sel = 1'b1; #1;
        chk(req, host_rdata, exp);
    endtask

    initial begin
        int n;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        live = 1'b1;
        host_sel = 1'b0; #1;
        chk("R1 reset command", host_rdata, 16'h0001);
        rd_data("R1 reset data", 16'h0000);
        idle(4);

        cur_req = "R2";
        hwrite(1'b0, 2'b11, {4'hA, 3'b111, 8'h5A, 1'b1});
        host_sel = 1'b0; #1;
        chk("R2 layout and read-only flag", host_rdata, {4'hA, 3'b000, 8'h5A, 1'b0});
        idle(3);
        host_sel = 1'b0; #1;
        chk("R2 repeated reads unchanged", host_rdata, {4'hA, 3'b000, 8'h5A, 1'b1});

        cur_req = "R7";
        hwrite(1'b1, 2'b11, 16'h1234);
        hwrite(1'b1, 2'b01, 16'hFFFF);
        hwrite(1'b1, 2'b10, 16'hEEEE);
        rd_data("R7 partial writes ignored", 16'h1234);

        cur_req = "R3";
        hwrite(1'b0, 2'b11, cmdw(4'b0011, 8'h05));
        wait_flag(n);
        chk("R3 write busy cycles", 16'(n), 16'd3);
        rd_data("R3 read-back data", 16'h1234);

        cur_req = "R9";
        hwrite(1'b1, 2'b11, 16'hBEEF);
        hwrite(1'b0, 2'b11, cmdw(4'b0011, 8'h00));
        wait_flag(n);
        hwrite(1'b1, 2'b11, 16'hCAFE);
        hwrite(1'b0, 2'b11, cmdw(4'b0011, 8'hFF));
        wait_flag(n);
        hwrite(1'b1, 2'b11, 16'h0000);
        hwrite(1'b0, 2'b11, cmdw(4'b0101, 8'h00));
        wait_flag(n);
        rd_data("R9 address zero", 16'hBEEF);
        hwrite(1'b0, 2'b11, cmdw(4'b0101, 8'hFF));
        wait_flag(n);
        rd_data("R9 top address", 16'hCAFE);

        cur_req = "R4";
        hwrite(1'b1, 2'b11, 16'h0F0F);
        hwrite(1'b0, 2'b11, cmdw(4'b0101, 8'h05));
        wait_flag(n);
        chk("R4 read busy cycles", 16'(n), 16'd2);
        rd_data("R4 read data", 16'h1234);

        cur_req = "R8";
        hwrite(1'b1, 2'b11, 16'h7777);
        hwrite(1'b0, 2'b11, cmdw(4'b0011, 8'h10));
        hwrite(1'b1, 2'b11, 16'h0BAD);
        hwrite(1'b0, 2'b11, cmdw(4'b0101, 8'h05));
        wait_flag(n);
        rd_data("R8 busy writes ignored", 16'h7777);
        host_sel = 1'b0; #1;
        chk("R8 command kept", host_rdata, {4'b0011, 3'b000, 8'h10, 1'b1});

        cur_req = "R5";
        hwrite(1'b1, 2'b11, 16'h4242);
        hwrite(1'b0, 2'b11, cmdw(4'b0000, 8'h05));
        wait_flag(n);
        chk("R5 reserved busy cycles", 16'(n), 16'd1);
        rd_data("R5 data unchanged", 16'h4242);
        hwrite(1'b0, 2'b11, cmdw(4'b1111, 8'h05));
        wait_flag(n);
        hwrite(1'b0, 2'b11, cmdw(4'b0101, 8'h05));
        wait_flag(n);
        rd_data("R5 memory untouched", 16'h1234);

        cur_req = "R6";
        hwrite(1'b0, 2'b11, cmdw(4'b0101, 8'h10));
        wait_flag(n);
        hwrite(1'b0, 2'b11, cmdw(4'b0101, 8'hFF));
        wait_flag(n);
        rd_data("R6 back-to-back command", 16'hCAFE);
        idle(4);

        live = 1'b0;
        report();
    end

endmodule